// File: doc/BRIEF.md
# Two-Stage Tagged Translation Cache

This block is a small fully associative cache of finished address translations. Each entry maps a guest virtual page straight to a host physical page. The mapping folds both translation steps into one entry: guest virtual to intermediate physical, and intermediate physical to host physical. An external table walker does the walk and writes the result through a fill port. The cache only stores and looks up completed translations.

Each entry is tagged with a virtual machine identifier, an address space identifier and a regime bit. The regime bit is 0 for guest and 1 for hypervisor. These tags let translations from several guests, several processes and the hypervisor share the array. The hypervisor's entries survive every change of guest context, so switching context needs no flush.

A lookup is matched in the same cycle it is presented, and its result is registered one cycle later. A miss raises a one-cycle walk request, which carries the missing page number. Pages are 4 KB, so the low 12 address bits pass through unchanged. An invalidate port removes entries in three ways: all entries, by virtual machine, or by virtual machine and address space.

Top module: `nested_xlat_tlb`

## Requirements
- R1: A lookup presented with `lk_valid_i` high in cycle N produces `rsp_valid_o` in cycle N+1. On a hit, `rsp_hit_o` is high in that same cycle and `rsp_paddr_o` equals the stored page number concatenated with `lk_vaddr_i[11:0]`.
- R2: A guest lookup (regime 0) hits only an entry that is valid and of regime 0, and whose page number, VMID and ASID are all equal to the lookup's.
- R3: A hypervisor lookup (regime 1) hits a valid regime-1 entry with the same page number, whatever the VMID and ASID. Lookups of one regime never hit entries of the other regime.
- R4: Every lookup cycle that misses sets `walk_req_o` high for exactly that one response cycle, with `walk_vpn_o` equal to the missing page number. A cycle with no lookup leaves `walk_req_o` low.
- R5: A fill chooses its slot in this order: an entry that already holds the same tag is rewritten; otherwise the lowest-indexed invalid entry is used; otherwise the entry at a round-robin pointer is replaced. The pointer starts at 0 after reset and advances by one, wrapping, only on a replacement.
- R6: An invalidate of kind 2'b00 clears every entry, of both regimes, in one cycle. Kind 2'b11 is reserved and has no effect.
- R7: An invalidate of kind 2'b01 clears every guest entry whose VMID equals `inv_vmid_i`. It leaves hypervisor entries and entries of other guests valid.
- R8: An invalidate of kind 2'b10 clears only the guest entries whose VMID and ASID both equal `inv_vmid_i` and `inv_asid_i`.
- R9: The fault flag stored with a fill is returned on `rsp_fault_o` with each hit of that entry. `rsp_fault_o` is low on a miss.
- R10: With `VMID_WIDE` = 1 the VMID is 16 bits and all 16 bits take part in matching. With `VMID_WIDE` = 0 it is 8 bits.
- R11: After reset no entry is valid, and `rsp_valid_o`, `rsp_hit_o` and `walk_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Guest virtual address to translate |
| lk_vmid_i | input | VMID_W | Current virtual machine identifier |
| lk_asid_i | input | ASID_W | Current address space identifier |
| lk_regime_i | input | 1 | Current regime (0 guest, 1 hypervisor) |
| rsp_valid_o | output | 1 | Result of last cycle's lookup is present |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_fault_o | output | 1 | Fault flag of the hit entry |
| rsp_paddr_o | output | PA_W | Host physical address |
| walk_req_o | output | 1 | Miss: walk needed |
| walk_vpn_o | output | VA_W-12 | Page number to walk |
| fill_en_i | input | 1 | Write a translation |
| fill_vpn_i | input | VA_W-12 | Guest virtual page number |
| fill_ppn_i | input | PA_W-12 | Host physical page number |
| fill_vmid_i | input | VMID_W | VMID tag |
| fill_asid_i | input | ASID_W | ASID tag |
| fill_regime_i | input | 1 | Regime tag |
| fill_fault_i | input | 1 | Fault flag to store |
| inv_en_i | input | 1 | Invalidate request |
| inv_kind_i | input | 2 | 00 all, 01 by VMID, 10 by VMID+ASID, 11 none |
| inv_vmid_i | input | VMID_W | VMID operand |
| inv_asid_i | input | ASID_W | ASID operand |

## Verification
The bench changes the VMID only in its upper byte, changes only the ASID, and changes only the regime. It expects a miss each time; a design that compared part of the tag, or ignored one tag, would return a stale translation to the wrong guest. It fills the same tag twice and then fills the array to capacity. A design that did not rewrite the matching entry would hold a duplicate and lose a slot. It also frees one slot in a full array and expects the next fill to take that free slot rather than the round-robin victim. A design that got this wrong would evict a live entry, which the bench sees as a miss. Finally, it runs the VMID and ASID invalidates next to a hypervisor entry. A design that ignored the regime bit there would flush the hypervisor's translations.

// File: rtl/nxt_pkg.sv
package nxt_pkg;
   localparam int PAGE_BITS = 12;

   localparam logic REGIME_GUEST = 1'b0;
   localparam logic REGIME_HYP   = 1'b1;

   typedef enum logic [1:0] {
      INV_ALL  = 2'b00,
      INV_VMID = 2'b01,
      INV_ASID = 2'b10,
      INV_NONE = 2'b11
   } inv_kind_e;
endpackage

// File: rtl/nxt_entry.sv
module nxt_entry
   import nxt_pkg::*;
#(
   parameter int VPN_W  = 28,
   parameter int PPN_W  = 28,
   parameter int VMID_W = 8,
   parameter int ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn_i,
   input  logic [VMID_W-1:0] lk_vmid_i,
   input  logic [ASID_W-1:0] lk_asid_i,
   input  logic              lk_regime_i,
   input  logic [VPN_W-1:0]  fl_vpn_i,
   input  logic [PPN_W-1:0]  fl_ppn_i,
   input  logic [VMID_W-1:0] fl_vmid_i,
   input  logic [ASID_W-1:0] fl_asid_i,
   input  logic              fl_regime_i,
   input  logic              fl_fault_i,
   input  logic              we_i,
   input  logic              inv_en_i,
   input  logic [1:0]        inv_kind_i,
   input  logic [VMID_W-1:0] inv_vmid_i,
   input  logic [ASID_W-1:0] inv_asid_i,
   output logic              valid_o,
   output logic              lk_hit_o,
   output logic              fl_same_o,
   output logic [PPN_W-1:0]  ppn_o,
   output logic              fault_o
);
   logic              vld_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [VMID_W-1:0] vmid_q;
   logic [ASID_W-1:0] asid_q;
   logic              regime_q;
   logic              fault_q;
   logic              kill;
   logic              is_guest;

   assign is_guest = (regime_q == REGIME_GUEST);

   // Hypervisor entries ignore VMID and ASID; guest entries need both.
   always_comb begin
      lk_hit_o = vld_q && (vpn_q == lk_vpn_i) && (regime_q == lk_regime_i) &&
                 (!is_guest || ((vmid_q == lk_vmid_i) && (asid_q == lk_asid_i)));
      fl_same_o = vld_q && (vpn_q == fl_vpn_i) && (regime_q == fl_regime_i) &&
                  (!is_guest || ((vmid_q == fl_vmid_i) && (asid_q == fl_asid_i)));
   end

   always_comb begin
      kill = 1'b0;
      if (inv_en_i) begin
         unique case (inv_kind_e'(inv_kind_i))
            INV_ALL:  kill = 1'b1;
            INV_VMID: kill = is_guest && (vmid_q == inv_vmid_i);
            INV_ASID: kill = is_guest && (vmid_q == inv_vmid_i) && (asid_q == inv_asid_i);
            INV_NONE: kill = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (we_i) begin
         vld_q <= 1'b1;
      end else if (kill) begin
         vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q    <= '0;
         ppn_q    <= '0;
         vmid_q   <= '0;
         asid_q   <= '0;
         regime_q <= REGIME_GUEST;
         fault_q  <= 1'b0;
      end else if (we_i) begin
         vpn_q    <= fl_vpn_i;
         ppn_q    <= fl_ppn_i;
         vmid_q   <= fl_vmid_i;
         asid_q   <= fl_asid_i;
         regime_q <= fl_regime_i;
         fault_q  <= fl_fault_i;
      end
   end

   assign valid_o = vld_q;
   assign ppn_o   = ppn_q;
   assign fault_o = fault_q;

   // R5: a written slot is valid on the next cycle
   p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> valid_o) else $error("filled entry not valid");

   // R7: guest-scoped invalidates never touch hypervisor entries
   p_hyp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en_i && (inv_kind_i != 2'b00) && valid_o && !is_guest && !we_i) |=> valid_o)
      else $error("hypervisor entry lost");
endmodule

// File: rtl/nxt_victim.sv
module nxt_victim #(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_en_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] same_i,
   output logic [ENTRIES-1:0] we_o
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] free_idx;
   logic             free_found;
   logic             any_same;
   logic             replace;

   assign any_same = |same_i;

   // Lowest-indexed invalid entry: scan downwards so the last write wins.
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end

   assign replace = fill_en_i && !any_same && !free_found;

   always_comb begin
      we_o = '0;
      if (fill_en_i) begin
         if (any_same)        we_o = same_i;
         else if (free_found) we_o[free_idx] = 1'b1;
         else                 we_o[rr_q] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (replace) begin
         rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R5: at most one slot is written per fill
   p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_o)) else $error("multiple slots written");

   // R5: pointer moves only on a replacement
   p_rr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en_i |=> $stable(rr_q)) else $error("pointer moved without fill");
endmodule

// File: rtl/nested_xlat_tlb.sv
module nested_xlat_tlb
   import nxt_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int VA_W      = 40,
   parameter int PA_W      = 40,
   parameter int ASID_W    = 8,
   parameter bit VMID_WIDE = 1'b0,
   localparam int VMID_W   = VMID_WIDE ? 16 : 8,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PA_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid_i,
   input  logic [VA_W-1:0]   lk_vaddr_i,
   input  logic [VMID_W-1:0] lk_vmid_i,
   input  logic [ASID_W-1:0] lk_asid_i,
   input  logic              lk_regime_i,
   output logic              rsp_valid_o,
   output logic              rsp_hit_o,
   output logic              rsp_fault_o,
   output logic [PA_W-1:0]   rsp_paddr_o,
   output logic              walk_req_o,
   output logic [VPN_W-1:0]  walk_vpn_o,
   input  logic              fill_en_i,
   input  logic [VPN_W-1:0]  fill_vpn_i,
   input  logic [PPN_W-1:0]  fill_ppn_i,
   input  logic [VMID_W-1:0] fill_vmid_i,
   input  logic [ASID_W-1:0] fill_asid_i,
   input  logic              fill_regime_i,
   input  logic              fill_fault_i,
   input  logic              inv_en_i,
   input  logic [1:0]        inv_kind_i,
   input  logic [VMID_W-1:0] inv_vmid_i,
   input  logic [ASID_W-1:0] inv_asid_i
);
   if (VA_W > 40 || VA_W <= PAGE_BITS) begin : g_bad_va
      $error("VA_W must lie in 13..40");
   end
   if (PA_W > 40 || PA_W <= PAGE_BITS) begin : g_bad_pa
      $error("PA_W must lie in 13..40");
   end
   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_depth
      $error("ENTRIES must lie in 2..64");
   end

   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] same_vec;
   logic [ENTRIES-1:0] we_vec;
   logic [ENTRIES-1:0] fault_vec;
   logic [PPN_W-1:0]   ppn_arr [ENTRIES];
   logic [PPN_W-1:0]   sel_ppn;
   logic               sel_fault;
   logic               any_hit;

   assign lk_vpn = lk_vaddr_i[VA_W-1:PAGE_BITS];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      nxt_entry #(
         .VPN_W (VPN_W),
         .PPN_W (PPN_W),
         .VMID_W(VMID_W),
         .ASID_W(ASID_W)
      ) entry_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .lk_vpn_i   (lk_vpn),
         .lk_vmid_i  (lk_vmid_i),
         .lk_asid_i  (lk_asid_i),
         .lk_regime_i(lk_regime_i),
         .fl_vpn_i   (fill_vpn_i),
         .fl_ppn_i   (fill_ppn_i),
         .fl_vmid_i  (fill_vmid_i),
         .fl_asid_i  (fill_asid_i),
         .fl_regime_i(fill_regime_i),
         .fl_fault_i (fill_fault_i),
         .we_i       (we_vec[g]),
         .inv_en_i   (inv_en_i),
         .inv_kind_i (inv_kind_i),
         .inv_vmid_i (inv_vmid_i),
         .inv_asid_i (inv_asid_i),
         .valid_o    (valid_vec[g]),
         .lk_hit_o   (hit_vec[g]),
         .fl_same_o  (same_vec[g]),
         .ppn_o      (ppn_arr[g]),
         .fault_o    (fault_vec[g])
      );
   end

   nxt_victim #(.ENTRIES(ENTRIES)) victim_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en_i(fill_en_i),
      .valid_i  (valid_vec),
      .same_i   (same_vec),
      .we_o     (we_vec)
   );

   // OR-mux: at most one entry hits, so a wired OR selects it.
   always_comb begin
      sel_ppn   = '0;
      sel_fault = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            sel_ppn   = sel_ppn | ppn_arr[i];
            sel_fault = sel_fault | fault_vec[i];
         end
      end
   end

   assign any_hit = |hit_vec;

   logic                 rsp_valid_q;
   logic                 rsp_hit_q;
   logic                 rsp_fault_q;
   logic [PPN_W-1:0]     rsp_ppn_q;
   logic [PAGE_BITS-1:0] rsp_off_q;
   logic                 walk_q;
   logic [VPN_W-1:0]     walk_vpn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_fault_q <= 1'b0;
         rsp_ppn_q   <= '0;
         rsp_off_q   <= '0;
         walk_q      <= 1'b0;
         walk_vpn_q  <= '0;
      end else begin
         rsp_valid_q <= lk_valid_i;
         rsp_hit_q   <= lk_valid_i && any_hit;
         rsp_fault_q <= lk_valid_i && any_hit && sel_fault;
         rsp_ppn_q   <= (lk_valid_i && any_hit) ? sel_ppn : '0;
         rsp_off_q   <= lk_vaddr_i[PAGE_BITS-1:0];
         walk_q      <= lk_valid_i && !any_hit;
         walk_vpn_q  <= lk_vpn;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_hit_o   = rsp_hit_q;
   assign rsp_fault_o = rsp_fault_q;
   assign rsp_paddr_o = {rsp_ppn_q, rsp_off_q};
   assign walk_req_o  = walk_q;
   assign walk_vpn_o  = walk_vpn_q;

   // R2: tags keep entries unique, so at most one hits
   p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)) else $error("several entries hit");

   // R1: response follows a lookup by one cycle
   p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> rsp_valid_o) else $error("missing response");

   // R4: no lookup, no response and no walk request
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |=> (!rsp_valid_o && !walk_req_o)) else $error("spurious walk");

   // R1: page offset passes through untranslated
   p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> (rsp_paddr_o[PAGE_BITS-1:0] == $past(lk_vaddr_i[PAGE_BITS-1:0])))
      else $error("offset altered");

   // R6: invalidate-all without a fill empties the array
   p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en_i && inv_kind_i == 2'b00 && !fill_en_i) |=> (valid_vec == '0))
      else $error("entries survive flush");
endmodule

// File: tb/nested_xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module nested_xlat_tlb_tb_top;
   localparam int ENT = 4;
   localparam int VAW = 40;
   localparam int PAW = 36;
   localparam int ASW = 8;
   localparam int VMW = 16;
   localparam int VPW = VAW - 12;
   localparam int PPW = PAW - 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           lk_valid = 1'b0;
   logic [VAW-1:0] lk_vaddr = '0;
   logic [VMW-1:0] lk_vmid = '0;
   logic [ASW-1:0] lk_asid = '0;
   logic           lk_regime = 1'b0;
   logic           rsp_valid, rsp_hit, rsp_fault, walk_req;
   logic [PAW-1:0] rsp_paddr;
   logic [VPW-1:0] walk_vpn;
   logic           fill_en = 1'b0;
   logic [VPW-1:0] fill_vpn = '0;
   logic [PPW-1:0] fill_ppn = '0;
   logic [VMW-1:0] fill_vmid = '0;
   logic [ASW-1:0] fill_asid = '0;
   logic           fill_regime = 1'b0;
   logic           fill_fault = 1'b0;
   logic           inv_en = 1'b0;
   logic [1:0]     inv_kind = 2'b00;
   logic [VMW-1:0] inv_vmid = '0;
   logic [ASW-1:0] inv_asid = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   nested_xlat_tlb #(
      .ENTRIES(ENT), .VA_W(VAW), .PA_W(PAW), .ASID_W(ASW), .VMID_WIDE(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_vmid_i(lk_vmid),
      .lk_asid_i(lk_asid), .lk_regime_i(lk_regime),
      .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
      .rsp_paddr_o(rsp_paddr), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
      .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
      .fill_vmid_i(fill_vmid), .fill_asid_i(fill_asid), .fill_regime_i(fill_regime),
      .fill_fault_i(fill_fault),
      .inv_en_i(inv_en), .inv_kind_i(inv_kind), .inv_vmid_i(inv_vmid), .inv_asid_i(inv_asid)
   );

   task automatic check(input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic fill(input logic [VPW-1:0] vpn, input logic [PPW-1:0] ppn,
                       input logic [VMW-1:0] vm, input logic [ASW-1:0] as,
                       input logic rg, input logic flt);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_vmid = vm;
      fill_asid = as; fill_regime = rg; fill_fault = flt;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic inval(input logic [1:0] kind, input logic [VMW-1:0] vm,
                        input logic [ASW-1:0] as);
      @(negedge clk);
      inv_en = 1'b1; inv_kind = kind; inv_vmid = vm; inv_asid = as;
      @(negedge clk);
      inv_en = 1'b0;
   endtask

   // Present for one cycle; the result is registered at the next edge
   // and sampled at the following falling edge.
   task automatic look(input logic [VPW-1:0] vpn, input logic [11:0] off,
                       input logic [VMW-1:0] vm, input logic [ASW-1:0] as,
                       input logic rg);
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_vmid = vm; lk_asid = as; lk_regime = rg;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_hit(input string rq, input logic [VPW-1:0] vpn,
                             input logic [VMW-1:0] vm, input logic [ASW-1:0] as,
                             input logic rg, input logic [PPW-1:0] ppn);
      look(vpn, 12'h5C3, vm, as, rg);
      check(rq, "hit", rsp_hit, 1);
      check(rq, "paddr", rsp_paddr, {ppn, 12'h5C3});
   endtask

   task automatic expect_miss(input string rq, input logic [VPW-1:0] vpn,
                              input logic [VMW-1:0] vm, input logic [ASW-1:0] as,
                              input logic rg);
      look(vpn, 12'h010, vm, as, rg);
      check(rq, "miss", rsp_hit, 0);
      check(rq, "walk", walk_req, 1);
   endtask

   task automatic t_reset();
      check("R11", "rsp_valid", rsp_valid, 0);
      check("R11", "rsp_hit", rsp_hit, 0);
      check("R11", "walk_req", walk_req, 0);
      expect_miss("R11", 28'h0000000, 16'h0000, 8'h00, 1'b0);
   endtask

   task automatic t_basic();
      inval(2'b00, '0, '0);
      fill(28'h0012345, 24'hABCDE1, 16'h0102, 8'h05, 1'b0, 1'b0);
      fill(28'h0012346, 24'h0F0F0F, 16'h0102, 8'h05, 1'b0, 1'b1);
      look(28'h0012345, 12'h9A4, 16'h0102, 8'h05, 1'b0);
      check("R1", "valid", rsp_valid, 1);
      check("R1", "hit", rsp_hit, 1);
      check("R1", "paddr", rsp_paddr, {24'hABCDE1, 12'h9A4});
      check("R9", "fault clear", rsp_fault, 0);
      check("R4", "no walk on hit", walk_req, 0);
      look(28'h0012346, 12'hFFF, 16'h0102, 8'h05, 1'b0);
      check("R9", "fault set", rsp_fault, 1);
      check("R9", "paddr", rsp_paddr, {24'h0F0F0F, 12'hFFF});
      look(28'h0777777, 12'h000, 16'h0102, 8'h05, 1'b0);
      check("R4", "walk", walk_req, 1);
      check("R4", "walk vpn", walk_vpn, 28'h0777777);
      check("R9", "fault on miss", rsp_fault, 0);
      @(negedge clk);
      check("R4", "walk one cycle", walk_req, 0);
   endtask

   task automatic t_tags();
      // entry from t_basic: vpn 12345, vmid 0102, asid 05, guest
      expect_miss("R10", 28'h0012345, 16'h0202, 8'h05, 1'b0);
      expect_miss("R2", 28'h0012345, 16'h0102, 8'h06, 1'b0);
      expect_miss("R3", 28'h0012345, 16'h0102, 8'h05, 1'b1);
      expect_hit("R2", 28'h0012345, 16'h0102, 8'h05, 1'b0, 24'hABCDE1);
   endtask

   task automatic t_hyp();
      inval(2'b00, '0, '0);
      fill(28'h0AAAAAA, 24'h123456, 16'h0003, 8'h07, 1'b1, 1'b0);
      expect_hit("R3", 28'h0AAAAAA, 16'hBEEF, 8'h99, 1'b1, 24'h123456);
      expect_miss("R3", 28'h0AAAAAA, 16'h0003, 8'h07, 1'b0);
   endtask

   task automatic t_inval();
      inval(2'b00, '0, '0);
      fill(28'h0000001, 24'h000011, 16'h00A0, 8'h01, 1'b0, 1'b0);
      fill(28'h0000002, 24'h000022, 16'h00A0, 8'h02, 1'b0, 1'b0);
      fill(28'h0000003, 24'h000033, 16'h00B0, 8'h01, 1'b0, 1'b0);
      fill(28'h0000004, 24'h000044, 16'h00A0, 8'h01, 1'b1, 1'b0);
      inval(2'b10, 16'h00A0, 8'h01);
      expect_miss("R8", 28'h0000001, 16'h00A0, 8'h01, 1'b0);
      expect_hit("R8", 28'h0000002, 16'h00A0, 8'h02, 1'b0, 24'h000022);
      expect_hit("R8", 28'h0000003, 16'h00B0, 8'h01, 1'b0, 24'h000033);
      expect_hit("R8", 28'h0000004, 16'h0000, 8'h00, 1'b1, 24'h000044);
      inval(2'b01, 16'h00A0, 8'h00);
      expect_miss("R7", 28'h0000002, 16'h00A0, 8'h02, 1'b0);
      expect_hit("R7", 28'h0000003, 16'h00B0, 8'h01, 1'b0, 24'h000033);
      expect_hit("R7", 28'h0000004, 16'h00A0, 8'h01, 1'b1, 24'h000044);
      inval(2'b11, 16'h00B0, 8'h01);
      expect_hit("R6", 28'h0000003, 16'h00B0, 8'h01, 1'b0, 24'h000033);
      inval(2'b00, '0, '0);
      expect_miss("R6", 28'h0000003, 16'h00B0, 8'h01, 1'b0);
      expect_miss("R6", 28'h0000004, 16'h00A0, 8'h01, 1'b1);
   endtask

   task automatic t_overwrite();
      inval(2'b00, '0, '0);
      fill(28'h00000A0, 24'h0000A1, 16'h0055, 8'h01, 1'b0, 1'b0);
      fill(28'h00000A0, 24'h0000A2, 16'h0055, 8'h01, 1'b0, 1'b0);
      fill(28'h00000B0, 24'h0000B1, 16'h0055, 8'h01, 1'b0, 1'b0);
      fill(28'h00000C0, 24'h0000C1, 16'h0055, 8'h01, 1'b0, 1'b0);
      fill(28'h00000D0, 24'h0000D1, 16'h0055, 8'h09, 1'b0, 1'b0);
      expect_hit("R5", 28'h00000A0, 16'h0055, 8'h01, 1'b0, 24'h0000A2);
      expect_hit("R5", 28'h00000B0, 16'h0055, 8'h01, 1'b0, 24'h0000B1);
      expect_hit("R5", 28'h00000C0, 16'h0055, 8'h01, 1'b0, 24'h0000C1);
      expect_hit("R5", 28'h00000D0, 16'h0055, 8'h09, 1'b0, 24'h0000D1);
   endtask

   // Slots now: 0=A 1=B 2=C 3=D, pointer at 0.
   task automatic t_replace();
      fill(28'h00000E0, 24'h0000E1, 16'h0055, 8'h01, 1'b0, 1'b0);
      expect_miss("R5", 28'h00000A0, 16'h0055, 8'h01, 1'b0);
      expect_hit("R5", 28'h00000E0, 16'h0055, 8'h01, 1'b0, 24'h0000E1);
      fill(28'h00000F0, 24'h0000F1, 16'h0055, 8'h01, 1'b0, 1'b0);
      expect_miss("R5", 28'h00000B0, 16'h0055, 8'h01, 1'b0);
      expect_hit("R5", 28'h00000C0, 16'h0055, 8'h01, 1'b0, 24'h0000C1);
      inval(2'b10, 16'h0055, 8'h09);
      fill(28'h0000010, 24'h000101, 16'h0055, 8'h01, 1'b0, 1'b0);
      fill(28'h0000020, 24'h000201, 16'h0055, 8'h01, 1'b0, 1'b0);
      expect_miss("R5", 28'h00000C0, 16'h0055, 8'h01, 1'b0);
      expect_hit("R5", 28'h0000010, 16'h0055, 8'h01, 1'b0, 24'h000101);
      expect_hit("R5", 28'h0000020, 16'h0055, 8'h01, 1'b0, 24'h000201);
      expect_hit("R5", 28'h00000E0, 16'h0055, 8'h01, 1'b0, 24'h0000E1);
      expect_hit("R5", 28'h00000F0, 16'h0055, 8'h01, 1'b0, 24'h0000F1);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_tags();
      t_hyp();
      t_inval();
      t_overwrite();
      t_replace();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule